// File: doc/BRIEF.md
# Linked Three-Channel Timer Counters

This block holds three 16-bit up-counters. A small synchronous register bus programs them. Each channel has a run bit, a compare register, a control word and one output pin. Each counter counts up by one per clock while its run bit is set. When the count equals the compare value, the channel can reset its count and change its pin. The control word picks both actions.

A link register groups channels together. Once two or more channels are linked, a bus write to the count of any linked channel loads the same value into every linked counter. A channel in the group can also be told to reset whenever another grouped channel resets on its own compare match. This gives phase-aligned counters without software stepping each channel by hand.

The pin keeps its level through a stop. Rewriting the control word while the channel is stopped forces the pin to the programmed initial level. This gives software a known starting level before the next run.

Top module: `sync_timer_group`

## Requirements
- R1: After reset, all registers read 0, except the three compare registers, which read 0xFFFF. All pins are 0.
- R2: The run register at address 0x00 holds one bit per channel in bits 2..0. A channel whose bit is 1 adds one to its count every clock. A channel whose bit is 0 holds its count.
- R3: The link register at address 0x02 keeps only bits 2..0 of a write. All other bits always read 0.
- R4: Channel n has its count at address 0x10+8n. A count write loads only that channel if its link bit is 0, or if fewer than two link bits are 1.
- R5: Linking is in effect when at least two link bits are 1. Then a count write to any linked channel loads the written value into every linked channel in the same clock, and no other channel changes.
- R6: The control word sits at address 0x14+8n. Its bits 2..0 select the clear source: 000 means none, 001 means own match, 011 means linked. The compare value sits at address 0x12+8n. A running channel set to own match, whose count equals its compare value, loads 0 on the next clock.
- R7: A linked channel set to clear source 011 loads 0 on the same clock edge as another linked channel's own-match clear. A linked channel set to 000 is not affected.
- R8: On a match of a running channel, the pin changes according to control bits 5..4: 00 keeps it, 01 drives 0, 10 drives 1, 11 inverts it.
- R9: While a channel's run bit is 0, its pin keeps its last level and its count does not change, unless the bus acts on that channel.
- R10: A control write to a stopped channel sets its pin to control bit 6 on the next clock. A control write to a running channel leaves the pin alone.
- R11: A bus write to a count and an increment in the same clock: the written value is stored.
- R12: A read strobe returns the addressed register on the read data output in the next clock. With no strobe in the previous clock, the read data output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, one clock after the strobe |
| pin_out | output | 3 | Compare output pin of each channel |

## Verification
A wrong count, for example a missed preset on a linked channel or a clear one edge late, shows up at the next read of that count. It also shifts the next compare match, so the affected pin changes in the wrong cycle within one count period. A wrong pin update or initial-level load shows on `pin_out` in the very next clock. The bench steps a behavioural model every clock and compares both the pin vector and the read data on every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DW = 16;
    localparam logic [7:0] ADDR_RUN  = 8'h00;
    localparam logic [7:0] ADDR_LINK = 8'h02;
    localparam logic [7:0] CH_BASE   = 8'h10;
    localparam int         CH_STRIDE = 8;
    localparam logic [7:0] OFS_CNT   = 8'h00;
    localparam logic [7:0] OFS_CMP   = 8'h02;
    localparam logic [7:0] OFS_CTRL  = 8'h04;
    localparam int         INIT_BIT  = 6;

    typedef enum logic [2:0] {
        CLR_NONE   = 3'b000,
        CLR_OWN    = 3'b001,
        CLR_LINKED = 3'b011
    } clr_src_e;

    typedef enum logic [1:0] {
        IO_KEEP   = 2'b00,
        IO_LOW    = 2'b01,
        IO_HIGH   = 2'b10,
        IO_TOGGLE = 2'b11
    } io_mode_e;

    typedef struct packed {
        logic     init_lvl;
        io_mode_e mode;
        clr_src_e clr;
    } chan_ctrl_t;

    function automatic logic [7:0] chan_addr(int ch, logic [7:0] ofs);
        return CH_BASE + 8'(ch * CH_STRIDE) + ofs;
    endfunction

    function automatic logic [DW-1:0] ctrl_pack(chan_ctrl_t c);
        logic [DW-1:0] w;
        w = '0;
        w[2:0] = c.clr;
        w[5:4] = c.mode;
        w[INIT_BIT] = c.init_lvl;
        return w;
    endfunction

    function automatic logic pin_next(io_mode_e m, logic cur);
        case (m)
            IO_LOW:    return 1'b0;
            IO_HIGH:   return 1'b1;
            IO_TOGGLE: return ~cur;
            default:   return cur;
        endcase
    endfunction
endpackage

// File: rtl/tmr_link.sv
module tmr_link #(
    parameter int NCH = 3
) (
    input  logic [NCH-1:0] sel_i,
    input  logic [NCH-1:0] own_clr_i,
    output logic [NCH-1:0] active_o,
    output logic [NCH-1:0] peer_clr_o
);
    logic grouped;
    assign grouped  = ($countones(sel_i) > 1);
    assign active_o = grouped ? sel_i : '0;

    for (genvar g = 0; g < NCH; g++) begin : g_peer
        assign peer_clr_o[g] = active_o[g] &&
                               (|(own_clr_i & active_o & ~(NCH'(1) << g)));
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          cmp_we_i,
    input  logic          ctrl_we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          link_clr_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cmp_o,
    output chan_ctrl_t    ctrl_o,
    output logic          own_clr_o,
    output logic          pin_o
);
    logic [CW-1:0] cnt_q, cmp_q;
    chan_ctrl_t    ctrl_q;
    logic          pin_q;
    logic          hit;
    logic          peer_zero;

    assign hit       = run_i && (cnt_q == cmp_q);
    assign own_clr_o = hit && (ctrl_q.clr == CLR_OWN);
    assign peer_zero = link_clr_i && (ctrl_q.clr == CLR_LINKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            cmp_q  <= '1;
            ctrl_q <= '0;
            pin_q  <= 1'b0;
        end else begin
            if (load_i)
                cnt_q <= load_val_i;
            else if (own_clr_o || peer_zero)
                cnt_q <= '0;
            else if (run_i)
                cnt_q <= cnt_q + 1'b1;

            if (cmp_we_i)
                cmp_q <= wdata_i[CW-1:0];

            if (ctrl_we_i) begin
                ctrl_q.clr      <= clr_src_e'(wdata_i[2:0]);
                ctrl_q.mode     <= io_mode_e'(wdata_i[5:4]);
                ctrl_q.init_lvl <= wdata_i[INIT_BIT];
            end

            if (ctrl_we_i && !run_i)
                pin_q <= wdata_i[INIT_BIT];
            else if (hit)
                pin_q <= pin_next(ctrl_q.mode, pin_q);
        end
    end

    assign cnt_o  = cnt_q;
    assign cmp_o  = cmp_q;
    assign ctrl_o = ctrl_q;
    assign pin_o  = pin_q;

    assert_stop_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !load_i && !peer_zero) |=> $stable(cnt_q));

    assert_own_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (own_clr_o && !load_i) |=> (cnt_q == '0));

    assert_pin_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !ctrl_we_i) |=> $stable(pin_q));

    assert_init_level_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we_i && !run_i) |=> (pin_q == $past(wdata_i[INIT_BIT])));

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/sync_timer_group.sv
module sync_timer_group
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [7:0]     bus_addr,
    input  logic [15:0]    bus_wdata,
    input  logic           bus_we,
    input  logic           bus_re,
    output logic [15:0]    bus_rdata,
    output logic [NCH-1:0] pin_out
);
    logic [NCH-1:0] run_q, link_q;
    logic [NCH-1:0] active, own_clr, peer_clr;
    logic [NCH-1:0] load_req, load, cmp_we, ctrl_we;
    logic           linked_wr;
    logic [CW-1:0]  cnt_v [NCH];
    logic [CW-1:0]  cmp_v [NCH];
    chan_ctrl_t     ctrl_v [NCH];
    logic [DW-1:0]  rd_mux, rdata_q;

    assign linked_wr = |(load_req & active);

    tmr_link #(.NCH(NCH)) u_link (
        .sel_i      (link_q),
        .own_clr_i  (own_clr),
        .active_o   (active),
        .peer_clr_o (peer_clr)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign load_req[g] = bus_we && (bus_addr == chan_addr(g, OFS_CNT));
        assign cmp_we[g]   = bus_we && (bus_addr == chan_addr(g, OFS_CMP));
        assign ctrl_we[g]  = bus_we && (bus_addr == chan_addr(g, OFS_CTRL));
        assign load[g]     = load_req[g] || (active[g] && linked_wr);

        tmr_channel #(.CW(CW)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .run_i      (run_q[g]),
            .load_i     (load[g]),
            .load_val_i (bus_wdata[CW-1:0]),
            .cmp_we_i   (cmp_we[g]),
            .ctrl_we_i  (ctrl_we[g]),
            .wdata_i    (bus_wdata),
            .link_clr_i (peer_clr[g]),
            .cnt_o      (cnt_v[g]),
            .cmp_o      (cmp_v[g]),
            .ctrl_o     (ctrl_v[g]),
            .own_clr_o  (own_clr[g]),
            .pin_o      (pin_out[g])
        );

        assert_linked_preset_R5: assert property (@(posedge clk) disable iff (rst)
            (linked_wr && active[g]) |=> (cnt_v[g] == $past(bus_wdata[CW-1:0])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            link_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (bus_we && bus_addr == ADDR_RUN)
                run_q <= bus_wdata[NCH-1:0];
            if (bus_we && bus_addr == ADDR_LINK)
                link_q <= bus_wdata[NCH-1:0];
            rdata_q <= bus_re ? rd_mux : '0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_RUN)
            rd_mux[NCH-1:0] = run_q;
        if (bus_addr == ADDR_LINK)
            rd_mux[NCH-1:0] = link_q;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == chan_addr(i, OFS_CNT))  rd_mux = DW'(cnt_v[i]);
            if (bus_addr == chan_addr(i, OFS_CMP))  rd_mux = DW'(cmp_v[i]);
            if (bus_addr == chan_addr(i, OFS_CTRL)) rd_mux = ctrl_pack(ctrl_v[i]);
        end
    end

    assign bus_rdata = rdata_q;

    assert_link_reserved_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == ADDR_LINK) |=> (bus_rdata[DW-1:NCH] == '0));

    assert_idle_read_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> (bus_rdata == '0));
endmodule

// File: tb/sync_timer_group_bench.sv
module sync_timer_group_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    wire  [15:0] rdata;
    wire  [2:0]  pins;

    always #2.5 clk = ~clk;

    sync_timer_group u_sync_timer_group (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_we    (we),
        .bus_re    (re),
        .bus_rdata (rdata),
        .pin_out   (pins)
    );

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";
    bit    armed  = 1'b0;

    int m_cnt [3];
    int m_cmp [3];
    int m_ctl [3];
    int m_pin [3];
    int m_run, m_link, m_rd;

    function automatic int m_read(int a);
        if (a == 0) return m_run;
        if (a == 2) return m_link;
        for (int n = 0; n < 3; n++) begin
            if (a == 16 + 8*n)     return m_cnt[n];
            if (a == 16 + 8*n + 2) return m_cmp[n];
            if (a == 16 + 8*n + 4) return m_ctl[n];
        end
        return 0;
    endfunction

    task automatic model_step();
        int hit [3];
        int act [3];
        int nc [3];
        int np [3];
        int ones, src, a, w, tgt, mode;
        a = int'(addr);
        w = int'(wdata);
        ones = 0;
        for (int n = 0; n < 3; n++) ones += (m_link >> n) & 1;
        for (int n = 0; n < 3; n++) begin
            act[n] = (((m_link >> n) & 1) == 1 && ones >= 2) ? 1 : 0;
            hit[n] = (((m_run >> n) & 1) == 1 && m_cnt[n] == m_cmp[n]) ? 1 : 0;
        end
        src = 0;
        for (int n = 0; n < 3; n++)
            if (hit[n] == 1 && act[n] == 1 && (m_ctl[n] & 7) == 1) src = 1;
        tgt = -1;
        if (we) for (int n = 0; n < 3; n++) if (a == 16 + 8*n) tgt = n;
        for (int n = 0; n < 3; n++) begin
            nc[n] = m_cnt[n];
            if (tgt >= 0 && (n == tgt || (act[tgt] == 1 && act[n] == 1)))
                nc[n] = w;
            else if (hit[n] == 1 && (m_ctl[n] & 7) == 1)
                nc[n] = 0;
            else if (act[n] == 1 && (m_ctl[n] & 7) == 3 && src == 1)
                nc[n] = 0;
            else if (((m_run >> n) & 1) == 1)
                nc[n] = (m_cnt[n] + 1) & 16'hFFFF;
            np[n] = m_pin[n];
            mode = (m_ctl[n] >> 4) & 3;
            if (we && a == 16 + 8*n + 4 && ((m_run >> n) & 1) == 0)
                np[n] = (w >> 6) & 1;
            else if (hit[n] == 1) begin
                if (mode == 1) np[n] = 0;
                else if (mode == 2) np[n] = 1;
                else if (mode == 3) np[n] = 1 - m_pin[n];
            end
        end
        m_rd = re ? m_read(a) : 0;
        if (we) begin
            if (a == 0) m_run  = w & 7;
            if (a == 2) m_link = w & 7;
            for (int n = 0; n < 3; n++) begin
                if (a == 16 + 8*n + 2) m_cmp[n] = w;
                if (a == 16 + 8*n + 4) m_ctl[n] = w & 16'h0077;
            end
        end
        for (int n = 0; n < 3; n++) begin
            m_cnt[n] = nc[n];
            m_pin[n] = np[n];
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < 3; n++) begin
                m_cnt[n] = 0; m_cmp[n] = 16'hFFFF; m_ctl[n] = 0; m_pin[n] = 0;
            end
            m_run = 0; m_link = 0; m_rd = 0;
        end else begin
            model_step();
        end
        armed = 1'b1;
    end

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !rst) begin
            chk("pins", {13'd0, pins},
                16'(m_pin[0] | (m_pin[1] << 1) | (m_pin[2] << 2)));
            chk("rdata", rdata, 16'(m_rd));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        addr = 8'(a); wdata = 16'(d); we = 1'b1; re = 1'b0;
    endtask

    task automatic rd(int a);
        @(negedge clk);
        addr = 8'(a); we = 1'b0; re = 1'b1;
    endtask

    task automatic idle(int n);
        @(negedge clk);
        we = 1'b0; re = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        phase = "R1";
        rd(0); rd(2); rd(16); rd(18); rd(20); rd(34); idle(2);
        // R2: run bit per channel
        phase = "R2";
        wr(18, 16'h0100); wr(0, 1); idle(10); rd(16); rd(24);
        wr(0, 0); idle(3); rd(16); idle(2);
        // R3: link register reserved bits
        phase = "R3";
        wr(2, 16'hFFFF); rd(2); wr(2, 0); rd(2); idle(1);
        // R4: independent writes, single link bit
        phase = "R4";
        wr(2, 1); wr(16, 100); wr(24, 7); rd(16); rd(24); rd(32); idle(1);
        // R5: linked preset
        phase = "R5";
        wr(2, 3); wr(24, 16'h1234); rd(16); rd(24); rd(32);
        wr(32, 16'h0055); rd(16); rd(32); idle(1);
        // R6: own-match clear with toggle output
        phase = "R6";
        wr(2, 0); wr(16, 0); wr(18, 20); wr(20, 16'h0031); wr(0, 1);
        idle(70); rd(16); idle(1);
        // R7: linked clear
        phase = "R7";
        wr(0, 0); wr(2, 7); wr(16, 0); wr(18, 15);
        wr(28, 16'h0003); wr(36, 16'h0000); wr(26, 16'hFFFF); wr(34, 16'hFFFF);
        wr(0, 7); idle(50); rd(16); rd(24); rd(32); idle(1);
        // R8: output actions (drive low, drive high, toggle)
        phase = "R8";
        wr(0, 0); wr(2, 0);
        wr(24, 0); wr(26, 5); wr(28, 16'h0051);
        wr(32, 0); wr(34, 3); wr(36, 16'h0021);
        wr(0, 7); idle(40);
        // R9: stop holds pin and count
        phase = "R9";
        wr(0, 6); idle(30); rd(16); idle(1);
        // R10: initial level reload only while stopped
        phase = "R10";
        wr(20, 16'h0071); idle(2); wr(20, 16'h0031); idle(2);
        wr(0, 1); wr(20, 16'h0071); idle(5);
        // R11: bus write beats increment
        phase = "R11";
        wr(16, 16'h0200); rd(16); idle(3); rd(16); idle(2);
        // R12: read latency and idle read data
        phase = "R12";
        rd(2); idle(3); rd(18); rd(20); rd(36); idle(3);
        summary();
    end
endmodule